// File: doc/BRIEF.md
# Pedestal Averaging Accumulator

This block computes the mean DC offset of each storage cell of one channel of a switched-capacitor sampler. A start command opens a run over a configurable number of storage windows of 32 cells each. For every window the block fills a 32-entry FIFO of 24-bit running sums with zeros. It then takes 2^N passes of cell samples, where each accepted sample pops the head sum, adds the 12-bit sample to it and pushes the result back at the tail. When the last pass is in, every sum is shifted right by N and cut to 12 bits. These averages are written to a byte-wide external memory with two cells packed into three bytes.

The sample stream carries a cell index, and samples are only taken while the `collecting` output is high. The memory side is a plain write strobe with address and data that hold still for a programmable number of cycles per byte. N values above 12 are treated as 12, so the 24-bit sums cannot overflow.

Top module: `ped_avg_accum`

## Requirements
- R1: After reset, `busy`, `done`, `collecting` and `mem_we` are all low.
- R2: A start in idle makes `busy` high on the next cycle. The block then primes the FIFO for exactly 32 cycles with `collecting` low before `collecting` rises.
- R3: Samples are taken in ascending cell order 0..31. A sample with `smp_valid` low or with a `smp_cell` that differs from the expected next cell leaves the sums unchanged.
- R4: A window ends after exactly 32·2^N accepted samples, and `collecting` falls at that point.
- R5: Each cell's result is its 24-bit sample sum shifted right by N, keeping the low 12 bits (a window of all 4095 gives 4095).
- R6: For a pair of cells 2k (value A) and 2k+1 (value B) the three bytes written are, in order, A[7:0], then {B[3:0], A[11:8]}, then B[11:4].
- R7: The byte i (0..2) of pair k in window w goes to address (w·16 + k)·3 + i, and no other address is written.
- R8: Each byte is presented with `mem_we` high and address and data unchanged for H cycles, where H is the hold setting, and a setting of 0 acts as 1.
- R9: The run covers windows 0 to WINDOWS-1 in order, and each window is primed afresh.
- R10: One cycle after the final byte ends, `done` rises and `busy` falls. `done` stays high until the next accepted start clears it.
- R11: A start while `busy` is high has no effect on the run, and that includes a start in the last cycle of the final byte.
- R12: N and the hold setting are captured when a start is accepted, and changing those inputs during a run changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| repeat_log2 | input | LOG2_W | N: each window is taken 2^N times |
| hold_cycles | input | HOLD_W | Cycles each byte is held (0 acts as 1) |
| smp_valid | input | 1 | Sample present |
| smp_data | input | 12 | Sample value |
| smp_cell | input | CELL_W | Cell index of the sample |
| collecting | output | 1 | Samples are being taken |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | ADDR_W | Byte address |
| mem_data | output | 8 | Byte value |

## Verification
Two events can land in the same clock edge. A start can be sampled in the very cycle that the final byte's hold expires, at the same moment the block moves toward idle. The bench raises start exactly on that last cycle and then checks three things: `done` rises one cycle later, `busy` stays low, and neither collection nor writes resume. In a second run, a start together with changed N and hold inputs lands in the middle of sample collection. It is judged by the fact that every following byte address, value and hold length still matches the model built from the original settings.

// File: rtl/pa_pkg.sv
// Shared definitions for the pedestal averaging accumulator.
// Assumes 12-bit samples, so two results pack into exactly three bytes.
package pa_pkg;
    localparam int PED_W = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME,
        ST_COLLECT,
        ST_POP_LO,
        ST_POP_HI,
        ST_EMIT
    } pa_state_e;
endpackage

// File: rtl/pa_fifo.sv
// Circular FIFO holding the running sums of one window.
// Assumes DEPTH is a power of two. The head is readable combinationally,
// and push and pop in the same cycle are allowed even when the FIFO is full.
module pa_fifo #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [AW:0]      count;

    // Storage write at the tail
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // Head of queue
    always_comb head = mem[rd_ptr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < (AW+1)'(DEPTH)));  // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));  // R3
endmodule

// File: rtl/pa_byte_writer.sv
// Writes one packed pair of 12-bit results as three bytes to the
// external memory, holding each byte for a programmed number of cycles.
// Assumes go arrives only while idle. fin pulses once after the third byte.
module pa_byte_writer #(
    parameter int ADDR_W = 15,
    parameter int HOLD_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        go,
    input  logic [pa_pkg::PED_W-1:0]    p0,
    input  logic [pa_pkg::PED_W-1:0]    p1,
    input  logic [ADDR_W-1:0]           base,
    input  logic [HOLD_W-1:0]           hold,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [7:0]                  mem_data,
    output logic                        fin
);
    logic              active;
    logic [1:0]        byte_i;
    logic [HOLD_W-1:0] hold_cnt;
    logic [HOLD_W-1:0] hold_last;
    logic [ADDR_W-1:0] base_q;
    logic [7:0]        b0, b1, b2;

    // Last count of a byte; a zero setting behaves as one cycle
    always_comb hold_last = (hold == '0) ? '0 : hold - 1'b1;

    // Byte sequencing and hold timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            byte_i   <= '0;
            hold_cnt <= '0;
            fin      <= 1'b0;
            base_q   <= '0;
            b0       <= '0;
            b1       <= '0;
            b2       <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                active   <= 1'b1;
                byte_i   <= '0;
                hold_cnt <= '0;
                base_q   <= base;
                b0       <= p0[7:0];
                b1       <= {p1[3:0], p0[11:8]};
                b2       <= p1[11:4];
            end else if (active) begin
                if (hold_cnt == hold_last) begin
                    hold_cnt <= '0;
                    if (byte_i == 2'd2) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                        byte_i <= '0;
                    end else begin
                        byte_i <= byte_i + 1'b1;
                    end
                end else begin
                    hold_cnt <= hold_cnt + 1'b1;
                end
            end
        end
    end

    // Port view of the current byte
    always_comb begin
        mem_we   = active;
        mem_addr = base_q + ADDR_W'(byte_i);
        case (byte_i)
            2'd0:    mem_data = b0;
            2'd1:    mem_data = b1;
            default: mem_data = b2;
        endcase
    end

    AST_WE_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && hold_cnt != '0) |-> ($stable(mem_addr) && $stable(mem_data)));  // R8
    AST_FIN_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> ($past(mem_we) && !mem_we));  // R8
endmodule

// File: rtl/pa_ctrl.sv
// Run sequencer: primes the sum FIFO, steers read-add-write accumulation
// of in-order cell samples, then pops pairs of sums, averages them by
// shifting, and hands each pair to the byte writer.
// Assumes CELLS is even and a power of two.
module pa_ctrl #(
    parameter int CELLS   = 32,
    parameter int WINDOWS = 512,
    parameter int ACC_W   = 24,
    parameter int LOG2_W  = 4,
    parameter int HOLD_W  = 4,
    parameter int ADDR_W  = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [LOG2_W-1:0]          repeat_log2,
    input  logic [HOLD_W-1:0]          hold_cycles,
    input  logic                       smp_valid,
    input  logic [pa_pkg::PED_W-1:0]   smp_data,
    input  logic [$clog2(CELLS)-1:0]   smp_cell,
    input  logic [ACC_W-1:0]           fifo_head,
    input  logic                       wr_fin,
    output logic                       fifo_push,
    output logic                       fifo_pop,
    output logic [ACC_W-1:0]           fifo_wdata,
    output logic                       wr_go,
    output logic [pa_pkg::PED_W-1:0]   wr_p0,
    output logic [pa_pkg::PED_W-1:0]   wr_p1,
    output logic [ADDR_W-1:0]          wr_base,
    output logic [HOLD_W-1:0]          hold_q,
    output logic                       collecting,
    output logic                       busy,
    output logic                       done
);
    import pa_pkg::*;

    localparam int CELL_W   = $clog2(CELLS);
    localparam int PAIRS    = CELLS / 2;
    localparam int PAIR_W   = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam int WIN_W    = (WINDOWS > 1) ? $clog2(WINDOWS) : 1;
    localparam int MAX_LOG2 = ACC_W - PED_W;
    localparam int PASS_W   = MAX_LOG2 + 1;

    pa_state_e          state;
    logic [LOG2_W-1:0]  n_q;
    logic [LOG2_W-1:0]  n_in;
    logic [CELL_W-1:0]  prime_cnt;
    logic [CELL_W-1:0]  cell_exp;
    logic [PASS_W-1:0]  pass_cnt;
    logic [PASS_W-1:0]  pass_last;
    logic [PAIR_W-1:0]  pair_cnt;
    logic [WIN_W-1:0]   win_cnt;
    logic [ADDR_W-1:0]  base;
    logic [PED_W-1:0]   p0;
    logic [PED_W-1:0]   avg;
    logic               take;

    // Clamp the repeat exponent so sums cannot exceed the accumulator
    always_comb n_in = (repeat_log2 > LOG2_W'(MAX_LOG2)) ? LOG2_W'(MAX_LOG2) : repeat_log2;

    // Index of the last pass: 2^N - 1
    always_comb pass_last = ({{(PASS_W-1){1'b0}}, 1'b1} << n_q) - 1'b1;

    // A sample is taken only when collecting and in cell order
    always_comb take = (state == ST_COLLECT) && smp_valid && (smp_cell == cell_exp);

    // Average of the current head sum
    always_comb avg = PED_W'(fifo_head >> n_q);

    // FIFO steering: zeros while priming, recirculated sums while collecting
    always_comb begin
        fifo_push  = (state == ST_PRIME) || take;
        fifo_pop   = take || (state == ST_POP_LO) || (state == ST_POP_HI);
        fifo_wdata = (state == ST_PRIME) ? '0 : fifo_head + ACC_W'(smp_data);
    end

    // Hand-off to the byte writer and port flags
    always_comb begin
        wr_go      = (state == ST_POP_HI);
        wr_p0      = p0;
        wr_p1      = avg;
        wr_base    = base;
        collecting = (state == ST_COLLECT);
        busy       = (state != ST_IDLE);
    end

    // Run state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            done      <= 1'b0;
            n_q       <= '0;
            hold_q    <= '0;
            prime_cnt <= '0;
            cell_exp  <= '0;
            pass_cnt  <= '0;
            pair_cnt  <= '0;
            win_cnt   <= '0;
            base      <= '0;
            p0        <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state     <= ST_PRIME;
                        done      <= 1'b0;
                        n_q       <= n_in;
                        hold_q    <= hold_cycles;
                        win_cnt   <= '0;
                        base      <= '0;
                        prime_cnt <= '0;
                    end
                end
                ST_PRIME: begin
                    prime_cnt <= prime_cnt + 1'b1;
                    if (prime_cnt == CELL_W'(CELLS - 1)) begin
                        state    <= ST_COLLECT;
                        cell_exp <= '0;
                        pass_cnt <= '0;
                    end
                end
                ST_COLLECT: begin
                    if (take) begin
                        cell_exp <= cell_exp + 1'b1;
                        if (cell_exp == CELL_W'(CELLS - 1)) begin
                            pass_cnt <= pass_cnt + 1'b1;
                            if (pass_cnt == pass_last) begin
                                state    <= ST_POP_LO;
                                pair_cnt <= '0;
                            end
                        end
                    end
                end
                ST_POP_LO: begin
                    p0    <= avg;
                    state <= ST_POP_HI;
                end
                ST_POP_HI: begin
                    state <= ST_EMIT;
                end
                ST_EMIT: begin
                    if (wr_fin) begin
                        base <= base + ADDR_W'(3);
                        if (pair_cnt == PAIR_W'(PAIRS - 1)) begin
                            pair_cnt <= '0;
                            if (win_cnt == WIN_W'(WINDOWS - 1)) begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                            end else begin
                                win_cnt   <= win_cnt + 1'b1;
                                prime_cnt <= '0;
                                state     <= ST_PRIME;
                            end
                        end else begin
                            pair_cnt <= pair_cnt + 1'b1;
                            state    <= ST_POP_LO;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));  // R2
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);  // R10
    AST_DONE_CLEARED_BY_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(start));  // R10
    AST_COLLECT_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        collecting |-> busy);  // R3
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(n_q) && $stable(hold_q)));  // R12
endmodule

// File: rtl/ped_avg_accum.sv
// Pedestal averaging accumulator top: connects the run sequencer, the
// recirculating sum FIFO and the packed byte writer.
// Assumes 12-bit samples and an even, power-of-two cell count per window.
module ped_avg_accum #(
    parameter int CELLS   = 32,
    parameter int WINDOWS = 512,
    parameter int ACC_W   = 24,
    parameter int LOG2_W  = 4,
    parameter int HOLD_W  = 4,
    parameter int CELL_W  = $clog2(CELLS),
    parameter int ADDR_W  = $clog2(WINDOWS * (CELLS / 2) * 3)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [LOG2_W-1:0]         repeat_log2,
    input  logic [HOLD_W-1:0]         hold_cycles,
    input  logic                      smp_valid,
    input  logic [11:0]               smp_data,
    input  logic [CELL_W-1:0]         smp_cell,
    output logic                      collecting,
    output logic                      busy,
    output logic                      done,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [7:0]                mem_data
);
    logic             fifo_push;
    logic             fifo_pop;
    logic [ACC_W-1:0] fifo_wdata;
    logic [ACC_W-1:0] fifo_head;
    logic             wr_go;
    logic             wr_fin;
    logic [11:0]      wr_p0;
    logic [11:0]      wr_p1;
    logic [ADDR_W-1:0] wr_base;
    logic [HOLD_W-1:0] hold_q;

    pa_ctrl #(
        .CELLS(CELLS), .WINDOWS(WINDOWS), .ACC_W(ACC_W),
        .LOG2_W(LOG2_W), .HOLD_W(HOLD_W), .ADDR_W(ADDR_W)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .repeat_log2(repeat_log2), .hold_cycles(hold_cycles),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_cell(smp_cell),
        .fifo_head(fifo_head), .wr_fin(wr_fin),
        .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_wdata(fifo_wdata),
        .wr_go(wr_go), .wr_p0(wr_p0), .wr_p1(wr_p1), .wr_base(wr_base),
        .hold_q(hold_q), .collecting(collecting), .busy(busy), .done(done)
    );

    pa_fifo #(.WIDTH(ACC_W), .DEPTH(CELLS)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .pop(fifo_pop),
        .wdata(fifo_wdata), .head(fifo_head)
    );

    pa_byte_writer #(.ADDR_W(ADDR_W), .HOLD_W(HOLD_W)) i_writer (
        .clk(clk), .rst_n(rst_n), .go(wr_go), .p0(wr_p0), .p1(wr_p1),
        .base(wr_base), .hold(hold_q), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .fin(wr_fin)
    );

    AST_NO_WRITE_WHILE_COLLECTING: assert property (@(posedge clk) disable iff (!rst_n)
        collecting |-> !mem_we);  // R4
endmodule

// File: tb/test_ped_avg_accum.sv
module test_ped_avg_accum;
    localparam int WIN   = 3;
    localparam int CELLS = 32;
    localparam int AW    = $clog2(WIN * 16 * 3);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [3:0]    repeat_log2;
    logic [3:0]    hold_cycles;
    logic          smp_valid;
    logic [11:0]   smp_data;
    logic [4:0]    smp_cell;
    logic          collecting, busy, done, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_addr[$];
    int exp_data[$];

    always #10 clk = ~clk;

    ped_avg_accum #(.WINDOWS(WIN)) i_ped_avg_accum (
        .clk(clk), .rst_n(rst_n), .start(start), .repeat_log2(repeat_log2),
        .hold_cycles(hold_cycles), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_cell(smp_cell), .collecting(collecting), .busy(busy), .done(done),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FIFO-CHECK FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int sample_val(int w, int p, int c, bit maxval);
        if (maxval) return 4095;
        return (w * 709 + c * 131 + p * 53 + 17) % 4096;
    endfunction

    // Reference model: expected byte stream for the whole run
    task automatic build_expect(input int n, input bit maxval);
        exp_addr.delete();
        exp_data.delete();
        for (int w = 0; w < WIN; w++) begin
            for (int k = 0; k < CELLS / 2; k++) begin
                longint s0 = 0, s1 = 0;
                int a, b;
                for (int p = 0; p < (1 << n); p++) begin
                    s0 += sample_val(w, p, 2 * k, maxval);
                    s1 += sample_val(w, p, 2 * k + 1, maxval);
                end
                a = int'((s0 >> n) & 4095);
                b = int'((s1 >> n) & 4095);
                exp_addr.push_back((w * 16 + k) * 3);
                exp_data.push_back(a & 255);
                exp_addr.push_back((w * 16 + k) * 3 + 1);
                exp_data.push_back(((b & 15) << 4) | (a >> 8));
                exp_addr.push_back((w * 16 + k) * 3 + 2);
                exp_data.push_back(b >> 4);
            end
        end
    endtask

    task automatic run_case(input int n, input int hold, input bit disturb,
                            input bit maxval, input bit late_start);
        int heff = (hold == 0) ? 1 : hold;
        int pl = 0, c = 0, p = 0, w = 0, cyc = 0, run = 0, iter = 0;
        int cur_addr = -1, cur_data = -1;
        bit in_run = 0, prev_coll = 0, quiet = 1;
        build_expect(n, maxval);
        @(negedge clk);
        repeat_log2 = 4'(n);
        hold_cycles = 4'(hold);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        chk(done == 1'b0, "R10 done cleared by start", int'(done), 0);
        while (!collecting && pl < 100) begin
            pl++;
            @(negedge clk);
        end
        chk(pl == 32, "R2 priming length", pl, 32);
        forever begin
            iter++;
            if (iter > 60000) begin
                chk(1'b0, "watchdog run", iter, 0);
                break;
            end
            // Observe the write port
            if (mem_we) begin
                chk(!collecting, "R4 write during collect", int'(collecting), 0);
                if (!in_run || int'(mem_addr) != cur_addr) begin
                    if (in_run) chk(run == heff, "R8 hold length", run, heff);
                    if (exp_addr.size() == 0) begin
                        chk(1'b0, "R7 extra write", int'(mem_addr), -1);
                    end else begin
                        int ea = exp_addr.pop_front();
                        int ed = exp_data.pop_front();
                        chk(int'(mem_addr) == ea, "R7 address", int'(mem_addr), ea);
                        chk(int'(mem_data) == ed, "R5 R6 byte value", int'(mem_data), ed);
                    end
                    cur_addr = int'(mem_addr);
                    cur_data = int'(mem_data);
                    run = 1;
                    in_run = 1;
                end else begin
                    run++;
                    if (int'(mem_data) != cur_data)
                        chk(1'b0, "R8 data stable", int'(mem_data), cur_data);
                end
            end else if (in_run) begin
                chk(run == heff, "R8 hold length", run, heff);
                in_run = 0;
                if (exp_addr.size() == 0) break;
            end
            // Window end seen at the port
            if (prev_coll && !collecting)
                chk(c == 0 && p == 0, "R4 samples per window", c + 32 * p, 0);
            prev_coll = collecting;
            // Stimulus for the coming edge
            start = 1'b0;
            smp_valid = 1'b0;
            if (late_start && mem_we && exp_addr.size() == 0 && run == heff)
                start = 1'b1;  // R11: start on the final byte's last cycle
            if (collecting) begin
                cyc++;
                if (disturb && cyc == 50) begin
                    start = 1'b1;           // R11 start while busy
                    repeat_log2 = 4'(n + 1); // R12 settings change mid-run
                    hold_cycles = 4'(hold + 2);
                end
                if (disturb && cyc % 7 == 3) begin
                    smp_valid = 1'b0;
                    smp_data  = 12'hFFF;
                    smp_cell  = 5'(c);
                end else if (disturb && cyc % 5 == 1) begin
                    smp_valid = 1'b1;       // R3 out-of-order cell ignored
                    smp_cell  = 5'((c + 1) % 32);
                    smp_data  = 12'hABC;
                end else begin
                    smp_valid = 1'b1;
                    smp_cell  = 5'(c);
                    smp_data  = 12'(sample_val(w, p, c, maxval));
                    c++;
                    if (c == 32) begin
                        c = 0;
                        p++;
                        if (p == (1 << n)) begin
                            p = 0;
                            w++;
                        end
                    end
                end
            end
            @(negedge clk);
        end
        start = 1'b0;
        smp_valid = 1'b0;
        chk(w == WIN, "R9 windows covered", w, WIN);
        chk(exp_addr.size() == 0, "R7 missing writes", exp_addr.size(), 0);
        chk(done == 1'b0, "R10 done timing", int'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R10 done raised", int'(done), 1);
        chk(busy == 1'b0, "R10 busy dropped", int'(busy), 0);
        for (int i = 0; i < 40; i++) begin
            if (busy || collecting || mem_we || !done) quiet = 0;
            @(negedge clk);
        end
        chk(quiet, late_start ? "R11 late start ignored" : "R10 done holds", int'(quiet), 1);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        repeat_log2 = '0;
        hold_cycles = '0;
        smp_valid = 1'b0;
        smp_data = '0;
        smp_cell = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !collecting && !mem_we, "R1 reset state",
            int'({busy, done, collecting, mem_we}), 0);
        run_case(0, 0, 1'b0, 1'b0, 1'b0);
        run_case(2, 3, 1'b1, 1'b0, 1'b1);
        run_case(8, 2, 1'b0, 1'b1, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        $display("FIFO-CHECK FAIL watchdog: actual %0d expected %0d", 195000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule